// File: doc/BRIEF.md
# Burst Address Sequencer

This block drives the word address of a synchronous SRAM port through a four-beat burst. A load strobe captures a complete external address, and that address is the first beat. Later beats are produced inside the block. Only the two lowest address bits change, and every upper bit keeps the value captured at load. The block never crosses into the next aligned group of four words.

A static order select picks between two wrap orders. In the linear order the low pair counts up modulo four. In the interleaved order the low pair is the starting pair XORed with the beat number. An advance strobe moves the burst forward by one beat. A clock edge with neither strobe is a wait state, and the address holds. A load always wins over advance, so a new burst can start at any beat.

The design keeps the captured address and a separate two-bit beat counter. The output is formed from these two values and the order select. Reset is active-low. It asserts asynchronously and is released on a clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no load, `addr_o` is all zeros.
- R2: On a rising edge with `load_i` high, the full `addr_i` is captured, and `addr_o` equals it right after that edge. This is beat 0.
- R3: With `order_i` = 0 (linear), each advance sets `addr_o[1:0]` to the previous value plus one, modulo 4. For example, start 01 gives 10, 11, 00.
- R4: With `order_i` = 1 (interleaved), beat k has `addr_o[1:0]` equal to the start bits XOR k, for k = 0..3. For example, start 10 gives 11, 00, 01.
- R5: Bits `addr_o[AW-1:2]` keep their captured value for as long as no new load occurs.
- R6: A rising edge with `load_i` low and `adv_i` low leaves `addr_o` unchanged. This is a wait state.
- R7: A rising edge with both `load_i` and `adv_i` high captures `addr_i` as a new beat 0. Later advances step from the new start.
- R8: An advance after beat 3 returns `addr_o` to the captured starting address, in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| load_i | input | 1 | Capture `addr_i` as beat 0 of a new burst |
| adv_i | input | 1 | Step to the next beat when no load is present |
| order_i | input | 1 | Wrap order: 0 linear, 1 interleaved |
| addr_i | input | AW | External start address |
| addr_o | output | AW | Current burst word address |

## Verification
A beat counter that is wrong shows up on `addr_o[1:0]` on the first edge after an advance. Examples are a counter that skips a beat, fails to clear on load, or fails to wrap. The result is a low pair that breaks the linear or XOR sequence, or that does not return to the start after four steps. A corrupted captured address shows up on the upper bits at once, and it stays wrong until the next load. A counter that moves during a wait state shows up one edge later as a changed output where the address should hold.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVED = 1'b1} order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  adv_i,
  output beat_t beat_o
);
  beat_t beat_q, beat_d;
  logic  beat_en;

  always_comb begin
    beat_en = load_i | adv_i;
    beat_d  = beat_q;
    if (load_i)     beat_d = '0;
    else if (adv_i) beat_d = beat_q + beat_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat_o = beat_q;

  a_r7_load_clears_beat: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_o == '0));
  a_r8_beat_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && beat_o == 2'd3) |=> (beat_o == '0));
  a_r6_beat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(beat_o));
endmodule

// File: rtl/burst_addr_form.sv
module burst_addr_form
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 18
) (
  input  logic [AW-1:0] base_i,
  input  beat_t         beat_i,
  input  logic          order_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned UW = AW - BEAT_W;

  beat_t lo_lin, lo_ilv, lo_sel;

  always_comb begin
    lo_lin = base_i[BEAT_W-1:0] + beat_i;
    lo_ilv = base_i[BEAT_W-1:0] ^ beat_i;
    lo_sel = (order_e'(order_i) == ORD_INTERLEAVED) ? lo_ilv : lo_lin;
  end

  generate
    if (UW > 0) begin : g_upper
      assign addr_o = {base_i[AW-1:BEAT_W], lo_sel};
    end else begin : g_lo_only
      assign addr_o = lo_sel;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic          rst_s_n;
  logic [AW-1:0] base_q, base_d;
  logic          base_en;
  beat_t         beat;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  always_comb begin
    base_en = load_i;
    base_d  = addr_i;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  burst_beat_ctr u_beat (
    .clk(clk), .rst_n(rst_s_n), .load_i(load_i), .adv_i(adv_i), .beat_o(beat));

  burst_addr_form #(.AW(AW)) u_form (
    .base_i(base_q), .beat_i(beat), .order_i(order_i), .addr_o(addr_o));

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_s_n)
    load_i |=> (addr_o == $past(addr_i)));
  a_r5_upper_stable: assert property (@(posedge clk) disable iff (!rst_s_n)
    !load_i |=> $stable(addr_o[AW-1:BEAT_W]));
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load_i && !adv_i) |=> (!$stable(order_i) || $stable(addr_o)));
  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load_i && adv_i && !order_i) |=>
      (order_i || addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int unsigned AW = 18;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n, load_i, adv_i, order_i;
  logic [AW-1:0] addr_i, addr_o;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o));

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] s, int k, logic ord);
    logic [1:0] lo;
    lo = ord ? (s[1:0] ^ 2'(k)) : (s[1:0] + 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  task automatic cycle(logic ld, logic adv, logic [AW-1:0] a);
    @(negedge clk);
    load_i = ld; adv_i = adv; addr_i = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 during reset", '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cycle(1'b0, 1'b0, 18'h3FFFF);
    check("R1 after release", '0);
  endtask

  task automatic t_order(logic ord, logic [AW-1:0] s, string req);
    order_i = ord;
    cycle(1'b1, 1'b0, s);
    check("R2 load", s);
    for (int k = 1; k < 4; k++) begin
      cycle(1'b0, 1'b1, ~s);
      check(req, expect_addr(s, k, ord));
      if (addr_o[AW-1:2] !== s[AW-1:2]) begin
        n_fail++; $display("FAIL R5: upper=%h expected=%h", addr_o[AW-1:2], s[AW-1:2]);
      end
      n_chk++;
    end
    cycle(1'b0, 1'b1, '0);
    check("R8 wrap", s);
  endtask

  task automatic t_wait();
    logic [AW-1:0] s = 18'h1C3A3;
    order_i = 1'b0;
    cycle(1'b1, 1'b0, s);
    cycle(1'b0, 1'b1, '0);
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b0, 18'h0BEEF);
      check("R6 wait", expect_addr(s, 1, 1'b0));
    end
    cycle(1'b0, 1'b1, '0);
    check("R6 resume", expect_addr(s, 2, 1'b0));
  endtask

  task automatic t_override();
    logic [AW-1:0] s1 = 18'h22220, s2 = 18'h15553;
    order_i = 1'b1;
    cycle(1'b1, 1'b0, s1);
    cycle(1'b0, 1'b1, '0);
    cycle(1'b0, 1'b1, '0);
    cycle(1'b1, 1'b1, s2);
    check("R7 override", s2);
    cycle(1'b0, 1'b1, '0);
    check("R7 restart beat", expect_addr(s2, 1, 1'b1));
  endtask

  initial begin
    rst_n = 1'b0; load_i = 0; adv_i = 0; order_i = 0; addr_i = '0;
    t_reset();
    t_order(1'b0, 18'h2A5B5, "R3 linear");
    t_order(1'b0, 18'h00003, "R3 linear from 11");
    t_order(1'b1, 18'h1F0F2, "R4 interleaved");
    t_order(1'b1, 18'h30001, "R4 interleaved from 01");
    t_wait();
    t_override();
    t_reset();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule